// File: doc/BRIEF.md
# Flit-to-Grant Synchronization Tracker

This block sits at one input port of a two-stage router built on elastic buffers. Flits from several packets can be in flight at once between the first router stage and the intermediate elastic buffer. Each packet chose its output port earlier, through look-ahead routing. The tracker keeps the output arbiters asking for the correct port while those flits move forward. Each time a head flit enters stage 1, the tracker records that head's chosen port in a short first-in first-out store. The store uses the same ready/valid handshake as the data buffers. The oldest stored port drives a one-hot request to the output arbiters.

When the current packet's tail flit crosses the switch, the tracker drops the oldest entry. In the next cycle it presents the following packet's port, together with a single-cycle update pulse that goes to every output. An output that is granting this input uses that pulse to reload its arbiter registers at the next edge. The arbiters and the crossbar are outside this block.

Top module: `fgs_sync_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `arb_req` is all zeros, `arb_upd` is 0 and `head_rdy` is 1.
- R2: A head accepted while the store is empty produces, in the next cycle, `arb_req` with exactly bit `head_port` set (bit i means output port i, i from 0 to NUM_OUT-1).
- R3: With no tail departure, `arb_req` keeps the oldest stored port, even when further heads are accepted.
- R4: An accepted tail departure removes the oldest entry, and the next cycle shows the next stored port. Ports leave in the same order as the heads arrived.
- R5: `arb_upd` is 1 for exactly the cycle after each accepted tail departure. Back-to-back departures keep it high for one cycle each.
- R6: A tail departure while the store is empty is ignored: no update pulse is produced and `arb_req` stays all zeros.
- R7: When all DEPTH entries are in use and no tail departs, `head_rdy` is 0 and an offered head is dropped. The dropped port never appears later in the drain order.
- R8: With FULL_PASS set, a full store that sees a tail departure raises `head_rdy`. The incoming head is then stored in that same cycle.
- R9: A push and a pop in the same cycle take effect together. With one entry stored, the next `arb_req` is the newly pushed port and the update pulse is raised.
- R10: After the last entry is removed, `arb_req` returns to all zeros in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld | input | 1 | A head flit enters stage 1 this cycle |
| head_port | input | PORT_W | Binary index of the output port the head chose |
| head_rdy | output | 1 | The port store can take an entry this cycle |
| tail_depart | input | 1 | The current packet's tail flit crosses the switch this cycle |
| arb_req | output | NUM_OUT | One-hot request of the current packet toward the output arbiters |
| arb_upd | output | 1 | Update pulse broadcast to every output |

## Verification
The stimulus starts with a single packet, to check the empty-to-busy step. Next, a burst of heads fills the store to the brim. This separates a tracker that holds the oldest port from one that follows the newest. Further heads are offered against the full store, both with and without a simultaneous tail departure, which tests the backpressure and the pass-through. Long drains and a pop combined with a push on a single entry then confirm first-in first-out order, pulse count and the return to idle.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
   localparam int unsigned FGS_NUM_OUT_DEF = 5;
   localparam int unsigned FGS_DEPTH_DEF   = 4;

   typedef enum logic {
      FULL_BLOCK = 1'b0,
      FULL_PASS  = 1'b1
   } full_policy_e;
endpackage

// File: rtl/fgs_port_fifo.sv
module fgs_port_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 3,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic [W-1:0]  din,
   input  logic          pop_en,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_en) wr_ptr <= wr_ptr + AW'(1);
         if (pop_en)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_en, pop_en})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_en) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_CNT);

   // R7: a full store only accepts a push alongside a pop
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && full) |-> pop_en);
   // R6: nothing is removed from an empty store
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> !empty);
endmodule

// File: rtl/fgs_req_decode.sv
module fgs_req_decode #(
   parameter int unsigned NUM_OUT = 5,
   parameter int unsigned PW      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic [PW-1:0]      port,
   output logic [NUM_OUT-1:0] req
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_req
      assign req[i] = valid && (port == PW'(i));
   end

   // R2: at most one output is requested at a time
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req));
   // R2: a valid stored port always names an existing output
   a_r2_port_range: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($countones(req) == 1));
endmodule

// File: rtl/fgs_upd_gen.sv
module fgs_upd_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic pop_en,
   output logic upd
);
   always_ff @(posedge clk) begin
      if (!rst_n) upd <= 1'b0;
      else        upd <= pop_en;
   end
endmodule

// File: rtl/fgs_sync_tracker.sv
module fgs_sync_tracker
   import fgs_pkg::*;
#(
   parameter int unsigned  NUM_OUT = FGS_NUM_OUT_DEF,
   parameter int unsigned  DEPTH   = FGS_DEPTH_DEF,
   parameter full_policy_e POLICY  = FULL_PASS,
   localparam int unsigned PORT_W  = $clog2(NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_vld,
   input  logic [PORT_W-1:0]  head_port,
   output logic               head_rdy,
   input  logic               tail_depart,
   output logic [NUM_OUT-1:0] arb_req,
   output logic               arb_upd
);
   if (NUM_OUT < 2) begin : g_chk_out
      $error("fgs_sync_tracker: NUM_OUT must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("fgs_sync_tracker: DEPTH must be a power of two, at least 2");
   end

   logic              empty, full, pop_en, push_en;
   logic [PORT_W-1:0] cur_port;

   assign pop_en = tail_depart && !empty;

   if (POLICY == FULL_PASS) begin : g_pass
      assign head_rdy = !full || pop_en;
   end else begin : g_block
      assign head_rdy = !full;
   end

   assign push_en = head_vld && head_rdy;

   fgs_port_fifo #(.DEPTH(DEPTH), .W(PORT_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_en (push_en),
      .din     (head_port),
      .pop_en  (pop_en),
      .dout    (cur_port),
      .empty   (empty),
      .full    (full)
   );

   fgs_req_decode #(.NUM_OUT(NUM_OUT), .PW(PORT_W)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (!empty),
      .port  (cur_port),
      .req   (arb_req)
   );

   fgs_upd_gen u_upd (
      .clk    (clk),
      .rst_n  (rst_n),
      .pop_en (pop_en),
      .upd    (arb_upd)
   );

   // R5: every update pulse follows a tail departure
   a_r5_upd_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      arb_upd |-> $past(tail_depart));
   // R3: the request holds while no packet leaves
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_en && !empty) |=> $stable(arb_req));
   // R10: an empty store raises no request
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (arb_req == '0));
   // R2: only existing outputs are pushed
   a_r2_push_range: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> (head_port < PORT_W'(NUM_OUT)));
endmodule

// File: tb/sim_fgs_sync_tracker.sv
module sim_fgs_sync_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NOUT  = 5;
   localparam int DEPTH = 4;

   typedef struct {
      logic [NOUT-1:0] req;
      logic            upd;
      string           tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            head_vld = 1'b0;
   logic [2:0]      head_port = '0;
   logic            tail_depart = 1'b0;
   logic            head_rdy;
   logic [NOUT-1:0] arb_req;
   logic            arb_upd;

   int   n_run = 0, n_fail = 0;
   bit   done = 0;
   int   model_q[$];
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fgs_sync_tracker u0 (
      .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head_port(head_port),
      .head_rdy(head_rdy), .tail_depart(tail_depart),
      .arb_req(arb_req), .arb_upd(arb_upd)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and records the expected outcome
   task automatic step(bit push, int port, bit tail, string tag);
      bit rdy_exp, pop, acc;
      exp_t e;
      @(negedge clk);
      head_vld    = push;
      head_port   = 3'(port);
      tail_depart = tail;
      #1;
      pop     = tail && (model_q.size() > 0);
      rdy_exp = (model_q.size() < DEPTH) || pop;
      check(tag, 32'(head_rdy), 32'(rdy_exp), "head_rdy");
      acc = push && rdy_exp;
      if (pop) void'(model_q.pop_front());
      if (acc) model_q.push_back(port);
      e.req = (model_q.size() > 0) ? NOUT'(1) << model_q[0] : '0;
      e.upd = pop;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares outputs a little after each edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, 32'(arb_req), 32'(e.req), "arb_req");
            check(e.tag, 32'(arb_upd), 32'(e.upd), "arb_upd");
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 32'(arb_req), 0, "arb_req in reset");
      check("R1", 32'(arb_upd), 0, "arb_upd in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(arb_req), 0, "arb_req after reset");
      check("R1", 32'(arb_upd), 0, "arb_upd after reset");
      check("R1", 32'(head_rdy), 1, "head_rdy after reset");

      step(0, 0, 1, "R6");          // tail on empty store
      step(0, 0, 0, "R6");
      step(1, 2, 0, "R2");          // first packet
      step(1, 4, 0, "R3");
      step(1, 0, 0, "R3");
      step(1, 1, 0, "R3");          // store now full
      step(1, 3, 0, "R7");          // dropped
      step(0, 0, 0, "R7");
      step(1, 3, 1, "R8");          // full pass-through
      step(0, 0, 1, "R4");
      step(0, 0, 1, "R5");          // back-to-back pops
      step(0, 0, 0, "R4");
      step(0, 0, 1, "R4");
      step(0, 0, 0, "R10");
      step(0, 0, 1, "R10");         // last entry leaves
      step(0, 0, 0, "R10");
      step(1, 1, 0, "R2");
      step(1, 2, 1, "R9");          // pop and push together on one entry
      step(0, 0, 0, "R9");
      step(0, 0, 1, "R5");
      step(0, 0, 0, "R5");
      step(0, 0, 0, "R10");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule